// File: doc/BRIEF.md
# VLIW Slot Dispatch and Writeback Scheduler

The block sits at the issue stage of a five-slot VLIW core. Each cycle it takes one bundle: five slots, each with a valid bit, an operation class and a destination register. It decides whether the bundle may issue. It then follows each issued operation through the fixed latency of its class and raises a writeback request, with the destination register, in the cycle the result is due. It does no arithmetic, reads no operands and handles no branch targets.

A bundle issues only when three things hold. Every valid slot uses a class that this slot may reach. The long-latency divide/root unit is not still recovering from an earlier operation. No future cycle would receive more than five writebacks. If any of these fails, the whole bundle is rejected and nothing from it takes effect. One cycle later `bundle_err_o` flags the rejection. Pending writebacks are held in a shift structure with one stage per remaining cycle. Each stage has five lanes that fill from lane 0 upward.

Top module: `vliw_dispatch_sched`

## Requirements
- R1: Class codes and their allowed slots (bit n of the mask is slot n): 0 const 11111, 1 alu 11111, 2 dspalu 00101, 3 dspmul 00110, 4 falu 01001, 5 ifmul 00110, 6 branch 01110, 7 dmem 11000, 8 dmemspec 10000, 9 tough 00010. A valid slot whose class is not allowed there causes rejection.
- R2: Latency is 1 for const and alu, 2 for dspalu, 17 for tough, and 3 for every other class. An accepted operation presented in cycle c shows its writeback in cycle c+latency.
- R3: After an accepted tough operation in cycle c, any tough operation in cycles c+1 to c+15 causes rejection. From cycle c+16 a tough operation is accepted.
- R4: A bundle is rejected if accepting it would give any future cycle more than five writebacks.
- R5: A rejected bundle has no effect. None of its writebacks appear, and it does not start the tough recovery.
- R6: A slot whose valid bit is low is ignored whatever its class. Class codes 10 to 15 on a valid slot cause rejection.
- R7: After reset there are no writebacks and `bundle_err_o` is low.
- R8: Writebacks due in one cycle take lanes from lane 0 upward with no gaps. Operations from older bundles come first, then those from newer bundles, and within one bundle they follow slot order.
- R9: `bundle_err_o` is high in cycle c+1 exactly when the bundle in cycle c was rejected. An empty bundle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | 5 | Valid bit per issue slot |
| slot_class_i | input | 5x4 | Operation class per slot |
| slot_dest_i | input | 5xREG_AW | Destination register per slot |
| wb_valid_o | output | NUM_WB | Writeback request per lane |
| wb_dest_o | output | NUM_WBxREG_AW | Destination register per lane |
| bundle_err_o | output | 1 | Previous cycle's bundle was rejected |

## Verification
The assertions assume that the bundle inputs are settled at each rising edge. The rejection properties assume a class field is meaningful only when its valid bit is high. The bench changes inputs only on falling edges and keeps them steady for a whole cycle. It puts illegal class codes on valid slots only in the rows meant to test rejection, and it pairs one invalid slot with an out-of-range code to show that such a slot is ignored. Table rows are spaced so each starts after the previous row's tough recovery and writebacks are done, so the overlap cases are exercised only by the directed tests.

// File: rtl/vliw_sched_pkg.sv
package vliw_sched_pkg;
  localparam int NUM_SLOTS   = 5;
  localparam int CLS_W       = 4;
  localparam int MAX_LAT     = 17;
  localparam int TOUGH_RECOV = 16;
  localparam int LAT_W       = $clog2(MAX_LAT + 1);

  typedef enum logic [CLS_W-1:0] {
    OP_CONST    = 4'd0,
    OP_ALU      = 4'd1,
    OP_DSPALU   = 4'd2,
    OP_DSPMUL   = 4'd3,
    OP_FALU     = 4'd4,
    OP_IFMUL    = 4'd5,
    OP_BRANCH   = 4'd6,
    OP_DMEM     = 4'd7,
    OP_DMEMSPEC = 4'd8,
    OP_TOUGH    = 4'd9
  } op_class_e;

  // bit n set: slot n may issue this class
  function automatic logic [NUM_SLOTS-1:0] slot_mask(input logic [CLS_W-1:0] c);
    case (c)
      OP_CONST, OP_ALU: return 5'b11111;
      OP_DSPALU:        return 5'b00101;
      OP_DSPMUL:        return 5'b00110;
      OP_FALU:          return 5'b01001;
      OP_IFMUL:         return 5'b00110;
      OP_BRANCH:        return 5'b01110;
      OP_DMEM:          return 5'b11000;
      OP_DMEMSPEC:      return 5'b10000;
      OP_TOUGH:         return 5'b00010;
      default:          return '0;
    endcase
  endfunction

  function automatic logic [LAT_W-1:0] op_latency(input logic [CLS_W-1:0] c);
    case (c)
      OP_CONST, OP_ALU: return LAT_W'(1);
      OP_DSPALU:        return LAT_W'(2);
      OP_TOUGH:         return LAT_W'(MAX_LAT);
      default:          return LAT_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/slot_check.sv
module slot_check
  import vliw_sched_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic             valid_i,
  input  logic [CLS_W-1:0] class_i,
  output logic             ok_o,
  output logic             tough_o,
  output logic [LAT_W-1:0] lat_o
);
  logic [NUM_SLOTS-1:0] mask;

  assign mask    = slot_mask(class_i);
  assign ok_o    = !valid_i || mask[SLOT];
  assign tough_o = valid_i && (class_i == OP_TOUGH);
  assign lat_o   = op_latency(class_i);
endmodule

// File: rtl/tough_tracker.sv
module tough_tracker #(
  parameter int RECOV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  output logic busy_o
);
  localparam int CW = $clog2(RECOV + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (issue_i)      cnt_q <= CW'(RECOV - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_no_issue_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !issue_i);

  if (RECOV > 1) begin : g_hold
    p_busy_after_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_i |=> busy_o);
  end
endmodule

// File: rtl/wb_queue.sv
module wb_queue #(
  parameter int NUM_SLOTS = 5,
  parameter int NUM_WB    = 5,
  parameter int REG_AW    = 7,
  parameter int MAX_LAT   = 17,
  parameter int LAT_W     = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                ins_en_i,
  input  logic [NUM_SLOTS-1:0]                req_v_i,
  input  logic [NUM_SLOTS-1:0][LAT_W-1:0]     req_lat_i,
  input  logic [NUM_SLOTS-1:0][REG_AW-1:0]    req_dest_i,
  output logic                                ovf_o,
  output logic [NUM_WB-1:0]                   wb_valid_o,
  output logic [NUM_WB-1:0][REG_AW-1:0]       wb_dest_o
);
  // stage k holds writebacks due k cycles after the current one
  logic [NUM_WB-1:0]              stg_v [MAX_LAT];
  logic [NUM_WB-1:0][REG_AW-1:0]  stg_d [MAX_LAT];
  logic [NUM_WB-1:0]              nxt_v [MAX_LAT];
  logic [NUM_WB-1:0][REG_AW-1:0]  nxt_d [MAX_LAT];

  always_comb begin
    int idx;
    int nk;
    ovf_o = 1'b0;
    for (int k = 0; k < MAX_LAT; k++) begin
      nk = (k < MAX_LAT - 1) ? k + 1 : k;
      if (k < MAX_LAT - 1) begin
        nxt_v[k] = stg_v[nk];
        nxt_d[k] = stg_d[nk];
      end else begin
        nxt_v[k] = '0;
        nxt_d[k] = '0;
      end
      idx = $countones(nxt_v[k]);
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (req_v_i[s] && req_lat_i[s] == LAT_W'(k + 1)) begin
          for (int w = 0; w < NUM_WB; w++) begin
            if (ins_en_i && idx == w) begin
              nxt_v[k][w] = 1'b1;
              nxt_d[k][w] = req_dest_i[s];
            end
          end
          idx = idx + 1;
        end
      end
      if (idx > NUM_WB) ovf_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_LAT; k++) begin
        stg_v[k] <= '0;
        stg_d[k] <= '0;
      end
    end else begin
      for (int k = 0; k < MAX_LAT; k++) begin
        stg_v[k] <= nxt_v[k];
        stg_d[k] <= nxt_d[k];
      end
    end
  end

  assign wb_valid_o = stg_v[0];
  assign wb_dest_o  = stg_d[0];

  p_lanes_packed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wb_valid_o & (wb_valid_o + 1'b1)) == '0));

  if (MAX_LAT > 1) begin : g_shift_chk
    p_entries_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(stg_v[1]) & ~stg_v[0]) == '0));
  end
endmodule

// File: rtl/vliw_dispatch_sched.sv
module vliw_dispatch_sched
  import vliw_sched_pkg::*;
#(
  parameter int REG_AW = 7,
  parameter int NUM_WB = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SLOTS-1:0]             slot_valid_i,
  input  logic [NUM_SLOTS-1:0][CLS_W-1:0]  slot_class_i,
  input  logic [NUM_SLOTS-1:0][REG_AW-1:0] slot_dest_i,
  output logic [NUM_WB-1:0]                wb_valid_o,
  output logic [NUM_WB-1:0][REG_AW-1:0]    wb_dest_o,
  output logic                             bundle_err_o
);
  logic [NUM_SLOTS-1:0]            slot_ok;
  logic [NUM_SLOTS-1:0]            slot_tough;
  logic [NUM_SLOTS-1:0][LAT_W-1:0] slot_lat;
  logic                            ovf;
  logic                            tough_busy;
  logic                            accept;
  logic                            tough_issue;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    slot_check #(.SLOT(g)) i_chk (
      .valid_i (slot_valid_i[g]),
      .class_i (slot_class_i[g]),
      .ok_o    (slot_ok[g]),
      .tough_o (slot_tough[g]),
      .lat_o   (slot_lat[g])
    );
  end

  assign accept      = (&slot_ok) && !ovf && !((|slot_tough) && tough_busy);
  assign tough_issue = accept && (|slot_tough);

  tough_tracker #(.RECOV(TOUGH_RECOV)) i_tough (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (tough_issue),
    .busy_o  (tough_busy)
  );

  wb_queue #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_WB    (NUM_WB),
    .REG_AW    (REG_AW),
    .MAX_LAT   (MAX_LAT),
    .LAT_W     (LAT_W)
  ) i_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_en_i   (accept),
    .req_v_i    (slot_valid_i),
    .req_lat_i  (slot_lat),
    .req_dest_i (slot_dest_i),
    .ovf_o      (ovf),
    .wb_valid_o (wb_valid_o),
    .wb_dest_o  (wb_dest_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bundle_err_o <= 1'b0;
    else         bundle_err_o <= !accept;
  end

  p_bad_slot_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&slot_ok) |=> bundle_err_o);

  p_overflow_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> bundle_err_o);
endmodule

// File: tb/test_vliw_dispatch_sched.sv
module test_vliw_dispatch_sched;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  typedef struct packed {
    logic [4:0]         v;
    logic [4:0][3:0]    c;
    logic [4:0][AW-1:0] d;
  } vec_t;

  // slot 4 written first in every concatenation
  localparam int NROWS = 12;
  localparam vec_t TBL [NROWS] = '{
    '{v:5'b11111, c:{4'd1,4'd1,4'd1,4'd1,4'd1}, d:{7'd24,7'd23,7'd22,7'd21,7'd20}},
    '{v:5'b11111, c:{4'd0,4'd0,4'd0,4'd0,4'd0}, d:{7'd29,7'd28,7'd27,7'd26,7'd25}},
    '{v:5'b11111, c:{4'd8,4'd4,4'd1,4'd3,4'd2}, d:{7'd34,7'd33,7'd32,7'd31,7'd30}},
    '{v:5'b11110, c:{4'd7,4'd7,4'd6,4'd5,4'd0}, d:{7'd38,7'd37,7'd36,7'd35,7'd0}},
    '{v:5'b00101, c:{4'd0,4'd0,4'd1,4'd0,4'd3}, d:{7'd0,7'd0,7'd50,7'd0,7'd51}},
    '{v:5'b10000, c:{4'd9,4'd0,4'd0,4'd0,4'd0}, d:{7'd52,7'd0,7'd0,7'd0,7'd0}},
    '{v:5'b00011, c:{4'd0,4'd0,4'd0,4'd9,4'd1}, d:{7'd0,7'd0,7'd0,7'd40,7'd41}},
    '{v:5'b01001, c:{4'd0,4'd12,4'd0,4'd0,4'd1}, d:{7'd0,7'd53,7'd0,7'd0,7'd54}},
    '{v:5'b00001, c:{4'd0,4'd0,4'd0,4'd12,4'd1}, d:{7'd0,7'd0,7'd0,7'd55,7'd42}},
    '{v:5'b00000, c:{4'd1,4'd1,4'd1,4'd1,4'd1}, d:{7'd1,7'd1,7'd1,7'd1,7'd1}},
    '{v:5'b01100, c:{4'd0,4'd6,4'd3,4'd0,4'd0}, d:{7'd0,7'd44,7'd43,7'd0,7'd0}},
    '{v:5'b00001, c:{4'd0,4'd0,4'd0,4'd0,4'd4}, d:{7'd0,7'd0,7'd0,7'd0,7'd45}}
  };

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [4:0]          slot_valid_i = '0;
  logic [4:0][3:0]     slot_class_i = '0;
  logic [4:0][AW-1:0]  slot_dest_i = '0;
  logic [4:0]          wb_valid_o;
  logic [4:0][AW-1:0]  wb_dest_o;
  logic                bundle_err_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vliw_dispatch_sched #(.REG_AW(AW), .NUM_WB(5)) i_vliw_dispatch_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_valid_i (slot_valid_i),
    .slot_class_i (slot_class_i),
    .slot_dest_i  (slot_dest_i),
    .wb_valid_o   (wb_valid_o),
    .wb_dest_o    (wb_dest_o),
    .bundle_err_o (bundle_err_o)
  );

  function automatic logic [4:0] ref_mask(input logic [3:0] c);
    case (c)
      4'd0, 4'd1: return 5'b11111;
      4'd2:       return 5'b00101;
      4'd3, 4'd5: return 5'b00110;
      4'd4:       return 5'b01001;
      4'd6:       return 5'b01110;
      4'd7:       return 5'b11000;
      4'd8:       return 5'b10000;
      4'd9:       return 5'b00010;
      default:    return 5'b00000;
    endcase
  endfunction

  function automatic int ref_lat(input logic [3:0] c);
    case (c)
      4'd0, 4'd1: return 1;
      4'd2:       return 2;
      4'd9:       return 17;
      default:    return 3;
    endcase
  endfunction

  function automatic logic ref_err(input vec_t b);
    logic e = 1'b0;
    for (int s = 0; s < 5; s++) begin
      logic [4:0] m = ref_mask(b.c[s]);
      if (b.v[s] && !m[s]) e = 1'b1;
    end
    return e;
  endfunction

  function automatic vec_t put(input vec_t b, input int s, input logic [3:0] c,
                               input logic [AW-1:0] d);
    vec_t r = b;
    r.v[s] = 1'b1;
    r.c[s] = c;
    r.d[s] = d;
    return r;
  endfunction

  task automatic step(input vec_t b);
    slot_valid_i = b.v;
    slot_class_i = b.c;
    slot_dest_i  = b.d;
    @(negedge clk_i);
  endtask

  task automatic check_err(input string tag, input logic exp);
    checks++;
    if (bundle_err_o !== exp) begin
      fails++;
      $display("FAIL %s: bundle_err actual %b expected %b", tag, bundle_err_o, exp);
    end
  endtask

  task automatic check_wb(input string tag, input logic [4:0] ev, input logic [4:0][AW-1:0] ed);
    logic bad = (wb_valid_o !== ev);
    for (int w = 0; w < 5; w++)
      if (ev[w] && wb_dest_o[w] !== ed[w]) bad = 1'b1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: wb actual %b/%h expected %b/%h", tag, wb_valid_o, wb_dest_o, ev, ed);
    end
  endtask

  task automatic run_row(input vec_t b, input int r);
    logic e = ref_err(b);
    vec_t idle = '0;
    step(b);
    check_err($sformatf("R1/R6/R9 row %0d", r), e);
    for (int k = 1; k <= 17; k++) begin
      logic [4:0]         ev = '0;
      logic [4:0][AW-1:0] ed = '0;
      int idx = 0;
      if (!e) begin
        for (int s = 0; s < 5; s++) begin
          if (b.v[s] && ref_lat(b.c[s]) == k) begin
            ev[idx] = 1'b1;
            ed[idx] = b.d[s];
            idx++;
          end
        end
      end
      check_wb($sformatf("R2/R5/R8 row %0d cycle +%0d", r, k), ev, ed);
      if (k < 17) step(idle);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t idle = '0;
    vec_t a, b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7: reset state
    check_wb("R7 reset", 5'b0, '0);
    check_err("R7 reset", 1'b0);

    for (int r = 0; r < NROWS; r++) run_row(TBL[r], r);

    // R3: tough unit recovery window
    a = put(idle, 1, 4'd9, 7'd60);
    step(a);
    check_err("R3 first tough", 1'b0);
    repeat (14) step(idle);
    step(put(idle, 1, 4'd9, 7'd61));
    check_err("R3 tough at +15", 1'b1);
    step(put(idle, 1, 4'd9, 7'd62));
    check_err("R3 tough at +16", 1'b0);
    check_wb("R2 tough latency 17", 5'b00001, {7'd0,7'd0,7'd0,7'd0,7'd60});
    repeat (15) step(idle);
    check_wb("R5 rejected tough silent", 5'b0, '0);
    step(idle);
    check_wb("R3 second tough writeback", 5'b00001, {7'd0,7'd0,7'd0,7'd0,7'd62});
    step(idle);

    // R4: writeback cap per cycle
    a = put(put(put(put(put(idle, 0, 4'd4, 7'd1), 1, 4'd3, 7'd2), 2, 4'd5, 7'd3),
            3, 4'd6, 7'd4), 4, 4'd7, 7'd5);
    step(a);
    check_err("R4 full bundle", 1'b0);
    step(put(idle, 0, 4'd2, 7'd6));
    check_err("R4 sixth via dspalu", 1'b1);
    step(put(idle, 0, 4'd1, 7'd7));
    check_err("R4 sixth via alu", 1'b1);
    check_wb("R4 five lanes", 5'b11111, {7'd5,7'd4,7'd3,7'd2,7'd1});
    step(idle);
    check_wb("R5 rejected ops absent", 5'b0, '0);
    repeat (3) step(idle);

    // R8: older bundle ahead of newer in one cycle
    a = put(put(put(idle, 1, 4'd3, 7'd10), 3, 4'd7, 7'd11), 4, 4'd8, 7'd12);
    b = put(put(idle, 0, 4'd2, 7'd13), 2, 4'd2, 7'd14);
    step(a);
    step(b);
    check_err("R4 exactly five accepted", 1'b0);
    step(idle);
    check_wb("R8 merge order", 5'b11111, {7'd14,7'd13,7'd12,7'd11,7'd10});
    step(idle);
    check_wb("R8 drained", 5'b0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule